// File: doc/BRIEF.md
# Configuration-Mode Entry Detector

This block decides when a group of pins normally used for motor PWM control is turned over to a serial configuration channel, and when they go back. It watches the bridge enable input, the high-side and low-side PWM inputs, the sensed level of the open-drain diagnostic line, a flag saying no diagnostic report is still waiting for acknowledge, and a configuration-permit bit. Entry needs a quiet pin pattern plus a low pulse on the diagnostic line whose width, counted in clock cycles, lies inside a fixed window. With the default settings that window is 2048 to 4096 clocks.

Once in configuration mode, the block stays there until the enable input goes high. It then waits for any storage write still in progress, asks for the working registers to be reloaded from nonvolatile storage, and waits for the reload to report completion. From the moment configuration mode is left until that completion, it asks for the diagnostic line to be held low. From configuration entry until the reload is done, it keeps the bridge blocked. Reset starts the block in the reload phase, so the bridge stays blocked after power-up until the first copy completes. The reload itself is a plain request/done handshake with the storage controller.

Top module: `cfg_entry_ctl`

## Requirements
- R1: After reset, the block is in the reload phase: `reload_req_o`, `diag_hold_low_o` and `bridge_block_o` are 1 and `cfg_mode_o` is 0. It leaves this phase on the first clock on which `reload_done_i` is 1, and all four outputs are then 0.
- R2: A pulse can only qualify while all of these hold: `enable_i` is 0, `errs_clear_i` is 1, every bit of `hs_pwm_i` is 1 and every bit of `ls_pwm_i` is 0. If any one of them fails, a pulse of valid width does not cause entry.
- R3: The pulse width is the number of consecutive clock edges on which `diag_line_i` is sampled 0 while the pattern qualifies. When the line is next sampled 1, `cfg_mode_o` becomes 1 one cycle later only if MIN_LOW ≤ width ≤ MAX_LOW. Pulses outside that range leave all outputs 0.
- R4: If the qualifying pattern is lost on any edge during a pulse, the measurement is dropped. A later low pulse is then measured from zero.
- R5: While `cfg_allow_i` is 0, no pulse causes entry.
- R6: In configuration mode, `enable_i` = 1 makes `cfg_mode_o` 0 one cycle later. While `write_busy_i` is 1 after that, `reload_req_o` stays 0.
- R7: After the exit, the first edge with `write_busy_i` = 0 raises `reload_req_o` one cycle later. It stays 1 until `reload_done_i` is sampled 1, after which the block is back in normal mode with all outputs 0.
- R8: `diag_hold_low_o` is 1 from configuration exit until the reload completes, and 0 in normal mode, during measurement and in configuration mode.
- R9: `bridge_block_o` is 1 in configuration mode, while waiting for a write, and during reload. It is 0 in normal mode and during measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Bridge enable input; 1 also ends configuration mode |
| hs_pwm_i | input | PHASES | High-side PWM inputs |
| ls_pwm_i | input | PHASES | Low-side PWM inputs |
| diag_line_i | input | 1 | Sensed level of the diagnostic line |
| errs_clear_i | input | 1 | 1 when no diagnostic report awaits acknowledge |
| cfg_allow_i | input | 1 | Configuration permit; 0 prevents entry |
| write_busy_i | input | 1 | Nonvolatile write in progress |
| reload_done_i | input | 1 | Register reload has completed |
| cfg_mode_o | output | 1 | Pins are in configuration mode |
| reload_req_o | output | 1 | Request to copy storage into working registers |
| diag_hold_low_o | output | 1 | Request to drive the diagnostic line low |
| bridge_block_o | output | 1 | Keep the bridge drivers off |

## Verification
On every cycle, the assertions check how the outputs relate to one another and to the inputs sampled one edge earlier. Configuration mode only starts after a released line under a qualifying, permitted pattern, and only ends on enable. The reload request only drops after done and only rises once no write is pending. Hold-low and bridge-block stay consistent with each mode. Only the bench scenarios can show the width arithmetic: the inclusive window edges, both at the default 2048/4096 setting and across a full sweep on a narrow instance. They also show that a pattern break restarts the count from zero, and that each single failing pin blocks entry.

// File: rtl/cfg_entry_pkg.sv
package cfg_entry_pkg;

    typedef enum logic [2:0] {
        M_RELOAD     = 3'd0,
        M_NORMAL     = 3'd1,
        M_MEASURE    = 3'd2,
        M_CONFIG     = 3'd3,
        M_WAIT_WRITE = 3'd4
    } mode_e;

    typedef struct packed {
        logic cfg_mode;
        logic reload_req;
        logic hold_low;
        logic bridge_block;
    } ctl_out_t;

    // Moore decode of the mode register into the four block outputs.
    function automatic ctl_out_t decode_mode(mode_e m);
        ctl_out_t o;
        o.cfg_mode     = (m == M_CONFIG);
        o.reload_req   = (m == M_RELOAD);
        o.hold_low     = (m == M_RELOAD) || (m == M_WAIT_WRITE);
        o.bridge_block = (m == M_RELOAD) || (m == M_WAIT_WRITE) || (m == M_CONFIG);
        return o;
    endfunction

endpackage

// File: rtl/pin_qualifier.sv
module pin_qualifier #(
    parameter int PHASES = 3
) (
    input  logic              enable_i,
    input  logic [PHASES-1:0] hs_pwm_i,
    input  logic [PHASES-1:0] ls_pwm_i,
    input  logic              errs_clear_i,
    input  logic              cfg_allow_i,
    output logic              qual_o
);
    logic [PHASES-1:0] phase_quiet;

    // A phase is quiet when its high-side input is 1 and its low-side input is 0.
    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        assign phase_quiet[p] = hs_pwm_i[p] & ~ls_pwm_i[p];
    end

    assign qual_o = ~enable_i & errs_clear_i & cfg_allow_i & (&phase_quiet);
endmodule

// File: rtl/low_pulse_meter.sv
module low_pulse_meter #(
    parameter int MIN_LOW = 2048,
    parameter int MAX_LOW = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic load_first,
    input  logic advance,
    output logic win_ok_o
);
    localparam int CW  = $clog2(MAX_LOW + 2);
    localparam int SAT = MAX_LOW + 1;
    localparam logic [CW-1:0] SAT_V = CW'(SAT);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_LOW);
    localparam logic [CW-1:0] MAX_V = CW'(MAX_LOW);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load_first) begin
            cnt <= CW'(1);
        end else if (advance && cnt != SAT_V) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign win_ok_o = (cnt >= MIN_V) && (cnt <= MAX_V);
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import cfg_entry_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     qual_i,
    input  logic     diag_line_i,
    input  logic     enable_i,
    input  logic     write_busy_i,
    input  logic     reload_done_i,
    input  logic     win_ok_i,
    output logic     load_first_o,
    output logic     advance_o,
    output ctl_out_t ctl_o
);
    mode_e mode_q, mode_d;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= M_RELOAD;
        else     mode_q <= mode_d;
    end

    always_comb begin
        mode_d       = mode_q;
        load_first_o = 1'b0;
        advance_o    = 1'b0;
        unique case (mode_q)
            M_RELOAD: begin
                if (reload_done_i) mode_d = M_NORMAL;
            end
            M_NORMAL: begin
                if (qual_i && !diag_line_i) begin
                    mode_d       = M_MEASURE;
                    load_first_o = 1'b1;
                end
            end
            M_MEASURE: begin
                if (!qual_i)          mode_d = M_NORMAL;
                else if (diag_line_i) mode_d = win_ok_i ? M_CONFIG : M_NORMAL;
                else                  advance_o = 1'b1;
            end
            M_CONFIG: begin
                if (enable_i) mode_d = M_WAIT_WRITE;
            end
            M_WAIT_WRITE: begin
                if (!write_busy_i) mode_d = M_RELOAD;
            end
            default: mode_d = M_RELOAD;
        endcase
    end

    assign ctl_o = decode_mode(mode_q);
endmodule

// File: rtl/cfg_entry_ctl.sv
module cfg_entry_ctl
    import cfg_entry_pkg::*;
#(
    parameter int PHASES  = 3,
    parameter int MIN_LOW = 2048,
    parameter int MAX_LOW = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic [PHASES-1:0] hs_pwm_i,
    input  logic [PHASES-1:0] ls_pwm_i,
    input  logic              diag_line_i,
    input  logic              errs_clear_i,
    input  logic              cfg_allow_i,
    input  logic              write_busy_i,
    input  logic              reload_done_i,
    output logic              cfg_mode_o,
    output logic              reload_req_o,
    output logic              diag_hold_low_o,
    output logic              bridge_block_o
);
    logic     qual;
    logic     load_first;
    logic     advance;
    logic     win_ok;
    ctl_out_t ctl;

    pin_qualifier #(.PHASES(PHASES)) u_qual (
        .enable_i     (enable_i),
        .hs_pwm_i     (hs_pwm_i),
        .ls_pwm_i     (ls_pwm_i),
        .errs_clear_i (errs_clear_i),
        .cfg_allow_i  (cfg_allow_i),
        .qual_o       (qual)
    );

    low_pulse_meter #(.MIN_LOW(MIN_LOW), .MAX_LOW(MAX_LOW)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .load_first (load_first),
        .advance    (advance),
        .win_ok_o   (win_ok)
    );

    mode_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .qual_i        (qual),
        .diag_line_i   (diag_line_i),
        .enable_i      (enable_i),
        .write_busy_i  (write_busy_i),
        .reload_done_i (reload_done_i),
        .win_ok_i      (win_ok),
        .load_first_o  (load_first),
        .advance_o     (advance),
        .ctl_o         (ctl)
    );

    assign cfg_mode_o      = ctl.cfg_mode;
    assign reload_req_o    = ctl.reload_req;
    assign diag_hold_low_o = ctl.hold_low;
    assign bridge_block_o  = ctl.bridge_block;
endmodule

// File: rtl/cfg_entry_chk.sv
module cfg_entry_chk (
    input logic clk,
    input logic rst,
    input logic enable_i,
    input logic diag_line_i,
    input logic errs_clear_i,
    input logic cfg_allow_i,
    input logic write_busy_i,
    input logic reload_done_i,
    input logic cfg_mode_o,
    input logic reload_req_o,
    input logic diag_hold_low_o,
    input logic bridge_block_o
);
    // R1
    reload_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        reload_req_o |-> (bridge_block_o && diag_hold_low_o));

    // R2
    entry_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_mode_o) |-> $past(!enable_i && errs_clear_i && diag_line_i));

    // R5
    entry_permit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_mode_o) |-> $past(cfg_allow_i));

    // R6
    exit_on_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_mode_o) |-> $past(enable_i));

    // R6
    reload_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reload_req_o) |-> $past(!write_busy_i));

    // R7
    reload_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(reload_req_o) |-> $past(reload_done_i));

    // R8
    cfg_line_free_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_mode_o |-> !diag_hold_low_o);

    // R9
    cfg_bridge_off_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_mode_o |-> bridge_block_o);

    // R7
    mode_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_mode_o, reload_req_o}));
endmodule

bind cfg_entry_ctl cfg_entry_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .enable_i        (enable_i),
    .diag_line_i     (diag_line_i),
    .errs_clear_i    (errs_clear_i),
    .cfg_allow_i     (cfg_allow_i),
    .write_busy_i    (write_busy_i),
    .reload_done_i   (reload_done_i),
    .cfg_mode_o      (cfg_mode_o),
    .reload_req_o    (reload_req_o),
    .diag_hold_low_o (diag_hold_low_o),
    .bridge_block_o  (bridge_block_o)
);

// File: tb/cfg_entry_ctl_test.sv
module cfg_entry_ctl_test;
    localparam int PH   = 3;
    localparam int SMIN = 8;
    localparam int SMAX = 16;
    localparam int BMIN = 2048;
    localparam int BMAX = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable_i = 1'b0;
    logic [PH-1:0] hs_pwm_i = '1;
    logic [PH-1:0] ls_pwm_i = '0;
    logic diag_line_i = 1'b1;
    logic errs_clear_i = 1'b1;
    logic cfg_allow_i = 1'b1;
    logic write_busy_i = 1'b0;
    logic reload_done_i = 1'b0;

    logic b_cfg, b_req, b_hold, b_blk;
    logic s_cfg, s_req, s_hold, s_blk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    cfg_entry_ctl #(.PHASES(PH), .MIN_LOW(BMIN), .MAX_LOW(BMAX)) uut (
        .clk(clk), .rst(rst), .enable_i(enable_i), .hs_pwm_i(hs_pwm_i),
        .ls_pwm_i(ls_pwm_i), .diag_line_i(diag_line_i), .errs_clear_i(errs_clear_i),
        .cfg_allow_i(cfg_allow_i), .write_busy_i(write_busy_i),
        .reload_done_i(reload_done_i), .cfg_mode_o(b_cfg), .reload_req_o(b_req),
        .diag_hold_low_o(b_hold), .bridge_block_o(b_blk)
    );

    cfg_entry_ctl #(.PHASES(PH), .MIN_LOW(SMIN), .MAX_LOW(SMAX)) uut_small (
        .clk(clk), .rst(rst), .enable_i(enable_i), .hs_pwm_i(hs_pwm_i),
        .ls_pwm_i(ls_pwm_i), .diag_line_i(diag_line_i), .errs_clear_i(errs_clear_i),
        .cfg_allow_i(cfg_allow_i), .write_busy_i(write_busy_i),
        .reload_done_i(reload_done_i), .cfg_mode_o(s_cfg), .reload_req_o(s_req),
        .diag_hold_low_o(s_hold), .bridge_block_o(s_blk)
    );

    // Output vector order: {cfg_mode, reload_req, hold_low, bridge_block}
    localparam logic [3:0] O_NORM   = 4'b0000;
    localparam logic [3:0] O_CFG    = 4'b1001;
    localparam logic [3:0] O_WAIT   = 4'b0011;
    localparam logic [3:0] O_RELOAD = 4'b0111;

    function automatic logic [3:0] outs(bit big);
        return big ? {b_cfg, b_req, b_hold, b_blk} : {s_cfg, s_req, s_hold, s_blk};
    endfunction

    task automatic chk(bit big, logic [3:0] exp, string tag);
        logic [3:0] act;
        act = outs(big);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse(int w);
        diag_line_i = 1'b0;
        repeat (w) tick();
        diag_line_i = 1'b1;
        tick();
    endtask

    // Walks any instance in config back to normal through write-wait and reload.
    task automatic back_to_normal();
        enable_i = 1'b1;
        write_busy_i = 1'b0;
        tick(); tick();
        reload_done_i = 1'b1;
        tick();
        reload_done_i = 1'b0;
        enable_i = 1'b0;
        tick();
    endtask

    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk(1'b1, O_RELOAD, "R1 reset state");
        chk(1'b0, O_RELOAD, "R1 reset state small");
        tick();
        chk(1'b0, O_RELOAD, "R1 waits for done");
        reload_done_i = 1'b1;
        tick();
        reload_done_i = 1'b0;
        chk(1'b1, O_NORM, "R1 normal after done");
        chk(1'b0, O_NORM, "R1 normal after done small");

        // R3 width sweep on the narrow instance
        for (int w = 1; w <= SMAX + 8; w++) begin
            pulse(w);
            chk(1'b0, (w >= SMIN && w <= SMAX) ? O_CFG : O_NORM, $sformatf("R3 width %0d", w));
            back_to_normal();
        end

        // R8/R9 outputs during measurement
        diag_line_i = 1'b0;
        repeat (5) tick();
        chk(1'b0, O_NORM, "R8 R9 during measure");
        diag_line_i = 1'b1;
        tick(); tick();

        // R2 each pin bit broken on its own
        for (int b = 0; b < 2 * PH; b++) begin
            if (b < PH) hs_pwm_i[b] = 1'b0; else ls_pwm_i[b - PH] = 1'b1;
            pulse(12);
            chk(1'b0, O_NORM, $sformatf("R2 pin bit %0d", b));
            hs_pwm_i = '1;
            ls_pwm_i = '0;
            back_to_normal();
        end
        enable_i = 1'b1;
        pulse(12);
        chk(1'b0, O_NORM, "R2 enable high");
        enable_i = 1'b0;
        errs_clear_i = 1'b0;
        pulse(12);
        chk(1'b0, O_NORM, "R2 errors pending");
        errs_clear_i = 1'b1;

        // R5 permit bit cleared
        cfg_allow_i = 1'b0;
        pulse(12);
        chk(1'b0, O_NORM, "R5 permit cleared");
        cfg_allow_i = 1'b1;
        tick();

        // R4 pattern lost mid pulse; the remaining 4 lows measure from zero
        diag_line_i = 1'b0;
        repeat (4) tick();
        hs_pwm_i[1] = 1'b0;
        tick();
        hs_pwm_i[1] = 1'b1;
        repeat (4) tick();
        diag_line_i = 1'b1;
        tick();
        chk(1'b0, O_NORM, "R4 abort on pattern change");
        back_to_normal();
        diag_line_i = 1'b0;
        repeat (3) tick();
        hs_pwm_i[2] = 1'b0;
        tick();
        hs_pwm_i[2] = 1'b1;
        repeat (SMIN) tick();
        diag_line_i = 1'b1;
        tick();
        chk(1'b0, O_CFG, "R4 fresh count after abort");

        // R6/R7/R8/R9 exit path with a pending write
        write_busy_i = 1'b1;
        tick();
        chk(1'b0, O_CFG, "R6 stays in config while enable low");
        enable_i = 1'b1;
        tick();
        chk(1'b0, O_WAIT, "R6 R8 R9 exit to write wait");
        repeat (3) tick();
        chk(1'b0, O_WAIT, "R6 no reload while busy");
        write_busy_i = 1'b0;
        tick();
        chk(1'b0, O_RELOAD, "R7 reload requested");
        repeat (2) tick();
        chk(1'b0, O_RELOAD, "R7 R8 reload held until done");
        reload_done_i = 1'b1;
        tick();
        reload_done_i = 1'b0;
        enable_i = 1'b0;
        chk(1'b0, O_NORM, "R7 back to normal");

        // R3 window edges at the default setting
        pulse(BMIN - 1);
        chk(1'b1, O_NORM, "R3 default width min-1");
        back_to_normal();
        pulse(BMIN);
        chk(1'b1, O_CFG, "R3 default width min");
        back_to_normal();
        pulse(BMAX);
        chk(1'b1, O_CFG, "R3 default width max");
        back_to_normal();
        pulse(BMAX + 1);
        chk(1'b1, O_NORM, "R3 default width max+1");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule